// File: doc/BRIEF.md
# SPI Flash Automatic Wait-Idle Poller

This block belongs to a serial flash controller. It takes over the bus after a write-type operation has been sent to the flash. Once the controller reports that a sector erase, a page program or a status-register write has finished, the poller keeps reading the flash status register until the write-in-progress flag clears. It then tells the controller, with a single pulse, that the flash can accept new work.

Each poll is one transaction with chip select low. First comes a command of 8 or 16 bits. An all-zero address phase and a dummy phase may follow; both are optional and both are configurable. Last come eight status bits. The serial clock runs at half the system clock. Each bus bit takes two system cycles: the low half, during which MOSI is stable and MISO is captured at its closing edge, and then the high half. When the flash reports busy, chip select goes high for a short gap and the whole transaction is issued again.

Top module: `spi_waitidle_poller`

## Requirements
- R1: With `cfg_en` high and `busy` low, a pulse on `op_done` with `op_kind` 1 (erase), 2 (program) or 3 (status write) pulls `cs_n` low in the next cycle and raises `busy`.
- R2: With `cfg_en` low, or with `op_kind` 0 (read), an `op_done` pulse leaves `cs_n` high and `busy` low.
- R3: The command phase sends `cfg_cmd[7:0]` MSB first when `cfg_cmd_16b` is 0. It sends `cfg_cmd[15:0]` MSB first when `cfg_cmd_16b` is 1.
- R4: With `cfg_addr_en` high, the command is followed by `cfg_addr_len + 1` bus bits with MOSI at 0. With `cfg_addr_en` low there is no address phase and `cfg_addr_len` has no effect.
- R5: With `cfg_dummy_en` high, `cfg_dummy_len` bus bits with MOSI at 0 come before the status bits. With `cfg_dummy_en` low, `cfg_dummy_len` has no effect.
- R6: Eight status bits are captured MSB first from `miso`, each at the end of the low half of its bus bit. The last bit received (status bit 0) is the busy flag.
- R7: When the busy flag is 1, `cs_n` goes high for exactly 2 system cycles, and then the full transaction is issued again.
- R8: When the busy flag is 0, `cs_n` goes high and `idle_done` is high for exactly one cycle.
- R9: `cs_n` stays low from the first command bit to the last status bit. Each bus bit is one cycle with `sclk_en` low followed by one cycle with `sclk_en` high, and MOSI holds its value over both cycles.
- R10: `busy` stays high from the cycle after the trigger up to and including the `idle_done` cycle. Any `op_done` pulse while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Enables automatic polling |
| cfg_cmd | input | 16 | Status-read command value |
| cfg_cmd_16b | input | 1 | 1 selects a 16-bit command, 0 an 8-bit command |
| cfg_addr_en | input | 1 | Enables the all-zero address phase |
| cfg_addr_len | input | 2 | Address length minus one, in bus bits |
| cfg_dummy_en | input | 1 | Enables the dummy phase |
| cfg_dummy_len | input | 6 | Dummy length in bus bits |
| op_done | input | 1 | Completion pulse of the preceding flash operation |
| op_kind | input | 2 | Type of that operation: 0 read, 1 erase, 2 program, 3 status write |
| miso | input | 1 | Serial data from the flash |
| cs_n | output | 1 | Active-low chip select |
| sclk_en | output | 1 | Serial clock level (high half of each bus bit) |
| mosi | output | 1 | Serial data to the flash |
| busy | output | 1 | Polling in progress |
| idle_done | output | 1 | One-cycle pulse: the flash reported idle |

## Verification
The assertions assume that the configuration fields do not change while `busy` is high, because the block reads them live in every phase. They also assume that `op_done` is a pulse of one cycle. The bench changes the configuration only while the poller is idle, and it drives every trigger for exactly one cycle. MISO is driven at the falling system edge inside the low half of each status bit, so it is stable at the capturing edge. Each run ends with a status whose bit 0 is 0, so every poll sequence completes.

// File: rtl/wi_pkg.sv
package wi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_GAP
    } wi_state_e;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_ADDR,
        PH_DUMMY,
        PH_STAT
    } wi_phase_e;

    localparam logic [1:0] KIND_READ   = 2'd0;
    localparam logic [1:0] KIND_ERASE  = 2'd1;
    localparam logic [1:0] KIND_PROG   = 2'd2;
    localparam logic [1:0] KIND_WRSTAT = 2'd3;

    localparam int STATUS_BITS = 8;
    localparam int BUSY_POS    = 0;

    // Operation kinds after which the flash must be polled
    function automatic logic needs_poll(input logic [1:0] kind);
        return (kind == KIND_ERASE) || (kind == KIND_PROG) || (kind == KIND_WRSTAT);
    endfunction

    // Phase order with empty phases skipped
    function automatic wi_phase_e phase_after(input wi_phase_e ph,
                                              input logic addr_on,
                                              input logic dummy_on);
        wi_phase_e nx;
        case (ph)
            PH_CMD:   nx = addr_on ? PH_ADDR : (dummy_on ? PH_DUMMY : PH_STAT);
            PH_ADDR:  nx = dummy_on ? PH_DUMMY : PH_STAT;
            default:  nx = PH_STAT;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/wi_txbits.sv
module wi_txbits
    import wi_pkg::*;
#(
    parameter int CMD_W = 16,
    parameter int CNT_W = 6
) (
    input  logic             active,
    input  wi_phase_e        phase,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CMD_W-1:0] cmd,
    input  logic             cmd_wide,
    output logic             mosi
);
    localparam int HALF_W = CMD_W / 2;

    logic [CMD_W-1:0] aligned;

    // Left-align the command so that bit index cnt counts from the MSB
    always_comb begin
        if (cmd_wide) aligned = cmd;
        else          aligned = {cmd[HALF_W-1:0], {HALF_W{1'b0}}};
    end

    // Address, dummy and status phases drive zero
    always_comb begin
        mosi = 1'b0;
        if (active && phase == PH_CMD)
            mosi = aligned[CMD_W - 1 - int'(cnt)];
    end
endmodule

// File: rtl/wi_status.sv
module wi_status
    import wi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic capture,
    input  logic miso,
    output logic busy_flag
);
    logic [STATUS_BITS-1:0] sreg;

    // MSB arrives first, so the busy flag ends up in the lowest bit
    always_ff @(posedge clk) begin
        if (rst)          sreg <= '0;
        else if (capture) sreg <= {sreg[STATUS_BITS-2:0], miso};
    end

    assign busy_flag = sreg[BUSY_POS];
endmodule

// File: rtl/wi_ctrl.sv
module wi_ctrl
    import wi_pkg::*;
#(
    parameter int DUMMY_W    = 6,
    parameter int CNT_W      = 6,
    parameter int GAP_CYCLES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               trig,
    input  logic               cmd_wide,
    input  logic               addr_en,
    input  logic [1:0]         addr_len,
    input  logic               dummy_en,
    input  logic [DUMMY_W-1:0] dummy_len,
    input  logic               busy_flag,
    output wi_state_e          state,
    output wi_phase_e          phase,
    output logic [CNT_W-1:0]   cnt,
    output logic               half,
    output logic               capture,
    output logic               done_pulse
);
    localparam int GAP_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;

    logic [CNT_W-1:0] cur_len;
    logic [GAP_W-1:0] gcnt;
    logic             dummy_on;
    logic             last_bit;

    assign dummy_on = dummy_en && (dummy_len != '0);

    always_comb begin
        case (phase)
            PH_CMD:   cur_len = cmd_wide ? CNT_W'(16) : CNT_W'(8);
            PH_ADDR:  cur_len = CNT_W'(addr_len) + CNT_W'(1);
            PH_DUMMY: cur_len = CNT_W'(dummy_len);
            default:  cur_len = CNT_W'(STATUS_BITS);
        endcase
    end

    assign last_bit = (cnt == cur_len - CNT_W'(1));
    assign capture  = (state == ST_XFER) && !half && (phase == PH_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            phase      <= PH_CMD;
            cnt        <= '0;
            half       <= 1'b0;
            gcnt       <= '0;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (trig) begin
                        state <= ST_XFER;
                        phase <= PH_CMD;
                        cnt   <= '0;
                        half  <= 1'b0;
                    end
                end
                ST_XFER: begin
                    if (!half) begin
                        half <= 1'b1;
                    end else begin
                        half <= 1'b0;
                        if (last_bit) begin
                            cnt <= '0;
                            if (phase == PH_STAT) begin
                                if (busy_flag) begin
                                    state <= ST_GAP;
                                    gcnt  <= '0;
                                end else begin
                                    state      <= ST_IDLE;
                                    done_pulse <= 1'b1;
                                end
                            end else begin
                                phase <= phase_after(phase, addr_en, dummy_on);
                            end
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                ST_GAP: begin
                    if (gcnt == GAP_W'(GAP_CYCLES - 1)) begin
                        state <= ST_XFER;
                        phase <= PH_CMD;
                        cnt   <= '0;
                        half  <= 1'b0;
                    end else begin
                        gcnt <= gcnt + GAP_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9: every high half follows a low half
    p_half_alternate_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_XFER && half) |=> !half);

    // R6: the busy decision is taken only after all eight status captures
    p_stat_in_range_r6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STAT && state == ST_XFER) |-> (cnt < CNT_W'(STATUS_BITS)));
endmodule

// File: rtl/spi_waitidle_poller.sv
module spi_waitidle_poller
    import wi_pkg::*;
#(
    parameter int CMD_W      = 16,
    parameter int DUMMY_W    = 6,
    parameter int GAP_CYCLES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_en,
    input  logic [CMD_W-1:0]   cfg_cmd,
    input  logic               cfg_cmd_16b,
    input  logic               cfg_addr_en,
    input  logic [1:0]         cfg_addr_len,
    input  logic               cfg_dummy_en,
    input  logic [DUMMY_W-1:0] cfg_dummy_len,
    input  logic               op_done,
    input  logic [1:0]         op_kind,
    input  logic               miso,
    output logic               cs_n,
    output logic               sclk_en,
    output logic               mosi,
    output logic               busy,
    output logic               idle_done
);
    localparam int CNT_W = (DUMMY_W > $clog2(CMD_W + 1)) ? DUMMY_W : $clog2(CMD_W + 1);

    wi_state_e        state;
    wi_phase_e        phase;
    logic [CNT_W-1:0] cnt;
    logic             half;
    logic             capture;
    logic             busy_flag;
    logic             trig;
    logic             active;

    assign trig = op_done && cfg_en && needs_poll(op_kind) && (state == ST_IDLE) && !idle_done;

    wi_ctrl #(
        .DUMMY_W   (DUMMY_W),
        .CNT_W     (CNT_W),
        .GAP_CYCLES(GAP_CYCLES)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .trig      (trig),
        .cmd_wide  (cfg_cmd_16b),
        .addr_en   (cfg_addr_en),
        .addr_len  (cfg_addr_len),
        .dummy_en  (cfg_dummy_en),
        .dummy_len (cfg_dummy_len),
        .busy_flag (busy_flag),
        .state     (state),
        .phase     (phase),
        .cnt       (cnt),
        .half      (half),
        .capture   (capture),
        .done_pulse(idle_done)
    );

    wi_status u_status (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .miso     (miso),
        .busy_flag(busy_flag)
    );

    assign active = (state == ST_XFER);

    wi_txbits #(
        .CMD_W(CMD_W),
        .CNT_W(CNT_W)
    ) u_tx (
        .active  (active),
        .phase   (phase),
        .cnt     (cnt),
        .cmd     (cfg_cmd),
        .cmd_wide(cfg_cmd_16b),
        .mosi    (mosi)
    );

    assign cs_n    = !active;
    assign sclk_en = active && half;
    assign busy    = (state != ST_IDLE) || idle_done;

    // R1: a qualifying trigger in the idle state starts a transaction
    p_auto_start_r1: assert property (@(posedge clk) disable iff (rst)
        (op_done && cfg_en && needs_poll(op_kind) && !busy) |=> (busy && !cs_n));

    // R7: after a transaction, chip select stays high for at least two cycles
    p_gap_min_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |=> cs_n);

    // R8: the completion pulse lasts one cycle, with chip select released
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        idle_done |=> !idle_done);
    p_done_cs_high_r8: assert property (@(posedge clk) disable iff (rst)
        idle_done |-> cs_n);

    // R9: the serial clock toggles only with chip select asserted
    p_clk_under_cs_r9: assert property (@(posedge clk) disable iff (rst)
        sclk_en |-> !cs_n);

    // R10: busy does not fall until the completion pulse has been given
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !idle_done) |=> busy);
endmodule

// File: tb/spi_waitidle_poller_tb.sv
module spi_waitidle_poller_tb;

    typedef struct {
        logic  cs_n;
        logic  sclk;
        logic  mosi;
        logic  busy;
        logic  done;
        logic  drv;
        string tag;
    } ent_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_en = 1'b0;
    logic [15:0] cfg_cmd = '0;
    logic        cfg_cmd_16b = 1'b0;
    logic        cfg_addr_en = 1'b0;
    logic [1:0]  cfg_addr_len = '0;
    logic        cfg_dummy_en = 1'b0;
    logic [5:0]  cfg_dummy_len = '0;
    logic        op_done = 1'b0;
    logic [1:0]  op_kind = '0;
    logic        miso = 1'b0;
    logic        cs_n, sclk_en, mosi, busy, idle_done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    ent_t       q[$];
    logic [7:0] stq[$];

    always #10 clk = ~clk;

    spi_waitidle_poller u_dut (
        .clk          (clk),
        .rst          (rst),
        .cfg_en       (cfg_en),
        .cfg_cmd      (cfg_cmd),
        .cfg_cmd_16b  (cfg_cmd_16b),
        .cfg_addr_en  (cfg_addr_en),
        .cfg_addr_len (cfg_addr_len),
        .cfg_dummy_en (cfg_dummy_en),
        .cfg_dummy_len(cfg_dummy_len),
        .op_done      (op_done),
        .op_kind      (op_kind),
        .miso         (miso),
        .cs_n         (cs_n),
        .sclk_en      (sclk_en),
        .mosi         (mosi),
        .busy         (busy),
        .idle_done    (idle_done)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    task automatic push_bit(input logic b, input logic drv, input string tag);
        ent_t e;
        e.cs_n = 1'b0; e.busy = 1'b1; e.done = 1'b0;
        e.mosi = b; e.drv = drv; e.tag = tag;
        e.sclk = 1'b0; q.push_back(e);
        e.sclk = 1'b1; q.push_back(e);
    endtask

    task automatic push_idle(input logic done, input string tag);
        ent_t e;
        e.cs_n = 1'b1; e.sclk = 1'b0; e.mosi = 1'b0; e.busy = 1'b1;
        e.done = done; e.drv = 1'b0; e.tag = tag;
        q.push_back(e);
    endtask

    // Reference model: expected output trace of a complete poll sequence
    task automatic build();
        int n;
        q.delete();
        foreach (stq[k]) begin
            n = cfg_cmd_16b ? 16 : 8;
            for (int i = n - 1; i >= 0; i--) push_bit(cfg_cmd[i], 1'b0, "R3");
            if (cfg_addr_en)
                for (int i = 0; i <= int'(cfg_addr_len); i++) push_bit(1'b0, 1'b0, "R4");
            if (cfg_dummy_en)
                for (int i = 0; i < int'(cfg_dummy_len); i++) push_bit(1'b0, 1'b0, "R5");
            for (int i = 7; i >= 0; i--) push_bit(1'b0, stq[k][i], "R6");
            if (stq[k][0]) begin
                push_idle(1'b0, "R7");
                push_idle(1'b0, "R7");
            end else begin
                push_idle(1'b1, "R8");
            end
        end
    endtask

    task automatic check_quiet(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            op_done = 1'b0;
            chk(req, "cs_n", cs_n, 1'b1);
            chk(req, "busy", busy, 1'b0);
            chk(req, "sclk_en", sclk_en, 1'b0);
        end
    endtask

    // Trigger, then compare every cycle against the reference trace
    task automatic run(input logic [1:0] kind, input bit mid_trig);
        build();
        @(negedge clk);
        op_kind = kind;
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
        chk("R1", "cs_n after trigger", cs_n, 1'b0);
        foreach (q[i]) begin
            chk("R9", "cs_n", cs_n, q[i].cs_n);
            chk("R9", "sclk_en", sclk_en, q[i].sclk);
            chk(q[i].tag, "mosi", mosi, q[i].mosi);
            chk("R10", "busy", busy, q[i].busy);
            chk("R8", "idle_done", idle_done, q[i].done);
            op_done = (mid_trig && (i == 5 || i == q.size() - 1)) ? 1'b1 : 1'b0;
            miso = q[i].drv;
            @(negedge clk);
        end
        op_done = 1'b0;
        miso = 1'b0;
        chk("R10", "busy after done", busy, 1'b0);
        chk("R8", "idle_done after done", idle_done, 1'b0);
        check_quiet("R10", 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R9", "reset cs_n", cs_n, 1'b1);
        chk("R10", "reset busy", busy, 1'b0);
        chk("R8", "reset idle_done", idle_done, 1'b0);
        chk("R9", "reset sclk_en", sclk_en, 1'b0);
        chk("R3", "reset mosi", mosi, 1'b0);

        // R1 R3 R6 R8: plain 8-bit poll, idle at once
        cfg_en = 1'b1;
        cfg_cmd = 16'h0005;
        stq = '{8'h00};
        run(2'd1, 1'b0);

        // R3 R4 R5 R7 R10: 16-bit command, address, dummy, busy twice, retriggers ignored
        cfg_cmd = 16'hA55A; cfg_cmd_16b = 1'b1;
        cfg_addr_en = 1'b1; cfg_addr_len = 2'd2;
        cfg_dummy_en = 1'b1; cfg_dummy_len = 6'd4;
        stq = '{8'h03, 8'h81, 8'hFE};
        run(2'd2, 1'b1);

        // R3 R4 R5: upper command byte, address length and dummy length have no effect
        cfg_cmd = 16'hFF35; cfg_cmd_16b = 1'b0;
        cfg_addr_en = 1'b0; cfg_addr_len = 2'd3;
        cfg_dummy_en = 1'b0; cfg_dummy_len = 6'd5;
        stq = '{8'h01, 8'h00};
        run(2'd3, 1'b0);

        // R4 R5: shortest address and a one-bit dummy
        cfg_cmd = 16'h00C3;
        cfg_addr_en = 1'b1; cfg_addr_len = 2'd0;
        cfg_dummy_en = 1'b1; cfg_dummy_len = 6'd1;
        stq = '{8'h7F, 8'h80};
        run(2'd1, 1'b0);

        // R2: disabled, and read-type operation
        @(negedge clk);
        cfg_en = 1'b0; op_kind = 2'd1; op_done = 1'b1;
        check_quiet("R2", 10);
        @(negedge clk);
        cfg_en = 1'b1; op_kind = 2'd0; op_done = 1'b1;
        check_quiet("R2", 10);

        summary();
    end
endmodule